// File: doc/BRIEF.md
# Memory-Mapped GPIO Register Bank

This block gives software a bank of general-purpose I/O lines behind a small memory-mapped register bus. Each clock cycle the bus presents one byte address, a write enable and write data; read data for the addressed register comes back on the next cycle. The number of lines equals the register width, which is chosen at elaboration time as 8, 16, 32 or 64 bits.

The lines are driven from an output latch. Software can load the latch whole, or change it with write-one-to-set and write-one-to-clear registers, so that one line can be changed without a read-modify-write. The latch can be read back. A single direction state decides which lines are outputs. It is reachable through two registers of opposite sense, and each always reads as the complement of the other. Pad levels pass through a two-flop synchronizer before software can read them.

Two elaboration options change how lines sit in the bus word. The first reverses the bit order, so line n appears at bit WIDTH-1-n. The second swaps the bytes of the bus word, and is legal only for 16-bit and 32-bit widths.

Top module: `gpio_mmio`

## Requirements
- R1: While reset is asserted, and after it is released, every line is an input with output enable low, and the output latch reads zero.
- R2: The level register (offset 0x00) returns each pad input level, 1 meaning high, through a two-flop synchronizer. A pad change made just before clock edge k is first returned by a read issued so that it samples at edge k+2. Read data is registered: the value for an address presented before an edge appears after that edge.
- R3: Writing offset 0x04 sets every latch bit whose written bit is 1. Bits written 0 keep their value.
- R4: Writing offset 0x08 clears every latch bit whose written bit is 1. Bits written 0 keep their value.
- R5: Writing offset 0x00 loads the output latch with the written word.
- R6: Offset 0x0C holds the output-direction view: 1 makes the line an output. A line's output enable equals its direction bit.
- R7: Offset 0x10 holds the input-direction view: writing 1 makes the line an input. Both views share one state, so reading 0x10 always returns the complement of 0x0C.
- R8: Reading offset 0x04 returns the output latch. Reading offset 0x08 returns zero.
- R9: Any other address, including offsets whose two low bits are not zero, reads zero, and a write to it changes neither the latch nor the direction.
- R10: Each line's driven value comes from the output latch even while that line is an input.
- R11: With mirrored order enabled, line n corresponds to bit WIDTH-1-n of every register, on both reads and writes.
- R12: With the byte-swap option, byte k of the bus word corresponds to byte WIDTH/8-1-k of the register, on both reads and writes. Selecting it with a 64-bit width, or selecting any width other than 8/16/32/64, stops elaboration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | ADDR_W | Byte address of the register |
| busWe | input | 1 | Write enable for this cycle |
| busWdata | input | REG_W | Write data |
| busRdata | output | REG_W | Registered read data for the previous cycle's address |
| padIn | input | REG_W | Pad input levels (asynchronous) |
| padOut | output | REG_W | Per-line driven value |
| padOe | output | REG_W | Per-line output enable |

## Verification
The bench checks that zero-written bits are untouched by set and clear writes. A design that assigned the written word instead of merging it would wipe neighbouring lines. It checks the read of the input-direction register after a write to the output-direction register, and the reverse. Separate storage for the two views would then return stale data. It counts the synchronizer latency exactly, reading the level register on three consecutive cycles after a pad change, which exposes a missing or extra stage. A second instance with mirrored order and byte swap uses asymmetric patterns, so a swapped, unmirrored or half-applied mapping lands on the wrong pad. Misaligned and unmapped writes are followed by pad checks, which catch a decoder that ignores the low address bits.

// File: rtl/gpio_mmio_pkg.sv
package gpio_mmio_pkg;

  localparam int OFS_LEVEL  = 'h00;
  localparam int OFS_SET    = 'h04;
  localparam int OFS_CLR    = 'h08;
  localparam int OFS_DIROUT = 'h0C;
  localparam int OFS_DIRIN  = 'h10;

  typedef enum logic [2:0] {
    RD_NONE,
    RD_LEVEL,
    RD_LATCH,
    RD_DIROUT,
    RD_DIRIN
  } rdSel_e;

  typedef struct packed {
    logic   wrLatch;
    logic   wrSet;
    logic   wrClr;
    logic   wrDirOut;
    logic   wrDirIn;
    rdSel_e rdSel;
  } busStrobe_t;

endpackage

// File: rtl/gpio_mmio_ctrl.sv
module gpio_mmio_ctrl
  import gpio_mmio_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  output busStrobe_t        strobe
);

  always_comb begin
    strobe       = '0;
    strobe.rdSel = RD_NONE;
    case (busAddr)
      ADDR_W'(OFS_LEVEL): begin
        strobe.rdSel   = RD_LEVEL;
        strobe.wrLatch = busWe;
      end
      ADDR_W'(OFS_SET): begin
        strobe.rdSel = RD_LATCH;
        strobe.wrSet = busWe;
      end
      ADDR_W'(OFS_CLR): begin
        strobe.rdSel = RD_NONE;
        strobe.wrClr = busWe;
      end
      ADDR_W'(OFS_DIROUT): begin
        strobe.rdSel    = RD_DIROUT;
        strobe.wrDirOut = busWe;
      end
      ADDR_W'(OFS_DIRIN): begin
        strobe.rdSel   = RD_DIRIN;
        strobe.wrDirIn = busWe;
      end
      default: strobe.rdSel = RD_NONE;
    endcase
  end

endmodule

// File: rtl/gpio_mmio_dp.sv
module gpio_mmio_dp
  import gpio_mmio_pkg::*;
#(
  parameter int REG_W      = 32,
  parameter bit MIRROR     = 1'b0,
  parameter bit BYTE_SWAP  = 1'b0,
  parameter int SYNC_DEPTH = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  busStrobe_t       strobe,
  input  logic [REG_W-1:0] busWdata,
  output logic [REG_W-1:0] busRdata,
  input  logic [REG_W-1:0] padIn,
  output logic [REG_W-1:0] padOut,
  output logic [REG_W-1:0] padOe
);

  localparam int NBYTES = REG_W / 8;

  // Line vector <-> register view. Mirror and byte swap are each their own
  // inverse and commute, so one function serves both directions.
  function automatic logic [REG_W-1:0] toView(input logic [REG_W-1:0] v);
    logic [REG_W-1:0] m;
    logic [REG_W-1:0] s;
    for (int i = 0; i < REG_W; i++) m[i] = MIRROR ? v[REG_W-1-i] : v[i];
    for (int i = 0; i < REG_W; i++)
      s[i] = BYTE_SWAP ? m[(NBYTES-1-(i/8))*8 + (i%8)] : m[i];
    return s;
  endfunction

  logic [REG_W-1:0] latchQ;
  logic [REG_W-1:0] dirQ;
  logic [REG_W-1:0] syncQ [SYNC_DEPTH];
  logic [REG_W-1:0] wLines;
  logic [REG_W-1:0] rdLines;

  assign wLines = toView(busWdata);

  // Pad input synchronizer chain
  for (genvar g = 0; g < SYNC_DEPTH; g++) begin : g_sync
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) syncQ[g] <= '0;
      else if (g == 0) syncQ[g] <= padIn;
      else syncQ[g] <= syncQ[(g == 0) ? 0 : g-1];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      latchQ <= '0;
      dirQ   <= '0;
    end else begin
      if (strobe.wrLatch)  latchQ <= wLines;
      if (strobe.wrSet)    latchQ <= latchQ | wLines;
      if (strobe.wrClr)    latchQ <= latchQ & ~wLines;
      if (strobe.wrDirOut) dirQ   <= wLines;
      if (strobe.wrDirIn)  dirQ   <= ~wLines;
    end
  end

  always_comb begin
    case (strobe.rdSel)
      RD_LEVEL:  rdLines = syncQ[SYNC_DEPTH-1];
      RD_LATCH:  rdLines = latchQ;
      RD_DIROUT: rdLines = dirQ;
      RD_DIRIN:  rdLines = ~dirQ;
      default:   rdLines = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) busRdata <= '0;
    else busRdata <= toView(rdLines);
  end

  assign padOut = latchQ;
  assign padOe  = dirQ;

endmodule

// File: rtl/gpio_mmio.sv
module gpio_mmio
  import gpio_mmio_pkg::*;
#(
  parameter int REG_W     = 32,
  parameter int ADDR_W    = 5,
  parameter bit MIRROR    = 1'b0,
  parameter bit BYTE_SWAP = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic [REG_W-1:0]  busWdata,
  output logic [REG_W-1:0]  busRdata,
  input  logic [REG_W-1:0]  padIn,
  output logic [REG_W-1:0]  padOut,
  output logic [REG_W-1:0]  padOe
);

  if (REG_W != 8 && REG_W != 16 && REG_W != 32 && REG_W != 64) begin : g_badWidth
    $error("gpio_mmio: REG_W must be 8, 16, 32 or 64");
  end
  if (BYTE_SWAP && REG_W == 64) begin : g_badSwap
    $error("gpio_mmio: byte swap is not available with a 64-bit width");
  end
  if (ADDR_W < 5) begin : g_badAddr
    $error("gpio_mmio: ADDR_W must cover offset 0x10");
  end

  busStrobe_t strobe;

  gpio_mmio_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .busAddr(busAddr),
    .busWe  (busWe),
    .strobe (strobe)
  );

  gpio_mmio_dp #(
    .REG_W    (REG_W),
    .MIRROR   (MIRROR),
    .BYTE_SWAP(BYTE_SWAP)
  ) dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .busWdata(busWdata),
    .busRdata(busRdata),
    .padIn   (padIn),
    .padOut  (padOut),
    .padOe   (padOe)
  );

endmodule

// File: rtl/gpio_mmio_chk.sv
module gpio_mmio_chk #(
  parameter int REG_W     = 32,
  parameter int ADDR_W    = 5,
  parameter bit MIRROR    = 1'b0,
  parameter bit BYTE_SWAP = 1'b0
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWe,
  input logic [REG_W-1:0]  busWdata,
  input logic [REG_W-1:0]  padOut,
  input logic [REG_W-1:0]  padOe
);

  localparam int NB = REG_W / 8;

  function automatic logic [REG_W-1:0] lines(input logic [REG_W-1:0] w);
    logic [REG_W-1:0] a;
    logic [REG_W-1:0] b;
    for (int i = 0; i < REG_W; i++) a[i] = BYTE_SWAP ? w[(NB-1-(i/8))*8 + (i%8)] : w[i];
    for (int i = 0; i < REG_W; i++) b[i] = MIRROR ? a[REG_W-1-i] : a[i];
    return b;
  endfunction

  logic isSet, isClr, isOut, isIn, isMapped;
  assign isSet    = busAddr == ADDR_W'('h04);
  assign isClr    = busAddr == ADDR_W'('h08);
  assign isOut    = busAddr == ADDR_W'('h0C);
  assign isIn     = busAddr == ADDR_W'('h10);
  assign isMapped = isSet || isClr || isOut || isIn || busAddr == ADDR_W'('h00);

  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (padOe == '0 && padOut == '0));

  assert_set_merge_R3: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && isSet) |=> padOut == ($past(padOut) | lines($past(busWdata))));

  assert_clr_merge_R4: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && isClr) |=> padOut == ($past(padOut) & ~lines($past(busWdata))));

  assert_dirout_oe_R6: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && isOut) |=> padOe == lines($past(busWdata)));

  assert_dirin_oe_R7: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && isIn) |=> padOe == ~lines($past(busWdata)));

  assert_unmapped_inert_R9: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && !isMapped) |=> ($stable(padOut) && $stable(padOe)));

endmodule

bind gpio_mmio gpio_mmio_chk #(
  .REG_W(REG_W), .ADDR_W(ADDR_W), .MIRROR(MIRROR), .BYTE_SWAP(BYTE_SWAP)
) chk_i (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe),
  .busWdata(busWdata), .padOut(padOut), .padOe(padOe)
);

// File: tb/gpio_mmio_tb_top.sv
`timescale 1ns/1ps
module gpio_mmio_tb_top;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2.5 clk = ~clk;

  // Instance A: 32 lines, plain order
  logic [4:0]  addrA = '0;
  logic        weA = 1'b0;
  logic [31:0] wdA = '0, rdA_q, padInA = 32'h5A5AA5A5, padOutA, padOeA;
  logic        rdReqA = 1'b0, armA = 1'b0;

  // Instance B: 16 lines, mirrored and byte swapped
  logic [4:0]  addrB = '0;
  logic        weB = 1'b0;
  logic [15:0] wdB = '0, rdB_q, padInB = '0, padOutB, padOeB;
  logic        rdReqB = 1'b0, armB = 1'b0;

  gpio_mmio #(.REG_W(32)) dut_i (
    .clk(clk), .rstN(rstN), .busAddr(addrA), .busWe(weA), .busWdata(wdA),
    .busRdata(rdA_q), .padIn(padInA), .padOut(padOutA), .padOe(padOeA));

  gpio_mmio #(.REG_W(16), .MIRROR(1'b1), .BYTE_SWAP(1'b1)) dutMs_i (
    .clk(clk), .rstN(rstN), .busAddr(addrB), .busWe(weB), .busWdata(wdB),
    .busRdata(rdB_q), .padIn(padInB), .padOut(padOutB), .padOe(padOeB));

  int total = 0;
  int bad = 0;
  logic [31:0] expQA[$];
  string       tagQA[$];
  logic [15:0] expQB[$];
  string       tagQB[$];

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Drivers: called at a falling edge, return at the next falling edge.
  task automatic wrA(logic [4:0] a, logic [31:0] d);
    addrA = a; wdA = d; weA = 1'b1;
    @(negedge clk);
    weA = 1'b0;
  endtask

  task automatic rdA(logic [4:0] a, logic [31:0] exp, string tag);
    addrA = a; rdReqA = 1'b1;
    expQA.push_back(exp); tagQA.push_back(tag);
    @(negedge clk);
    rdReqA = 1'b0;
  endtask

  task automatic wrB(logic [4:0] a, logic [15:0] d);
    addrB = a; wdB = d; weB = 1'b1;
    @(negedge clk);
    weB = 1'b0;
  endtask

  task automatic rdB(logic [4:0] a, logic [15:0] exp, string tag);
    addrB = a; rdReqB = 1'b1;
    expQB.push_back(exp); tagQB.push_back(tag);
    @(negedge clk);
    rdReqB = 1'b0;
  endtask

  // Monitor: read data registered at the edge where the request was seen.
  always @(posedge clk) begin
    armA <= rdReqA;
    armB <= rdReqB;
  end

  always @(negedge clk) begin
    if (armA && expQA.size() > 0) check(tagQA.pop_front(), 64'(rdA_q), 64'(expQA.pop_front()));
    if (armB && expQB.size() > 0) check(tagQB.pop_front(), 64'(rdB_q), 64'(expQB.pop_front()));
  end

  initial begin
    for (int i = 0; i < 20000; i++) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=hung expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) @(negedge clk);
    check("R1 oe in reset", 64'(padOeA), 64'h0);
    check("R1 out in reset", 64'(padOutA), 64'h0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 oe after reset", 64'(padOeA), 64'h0);
    check("R1 out after reset", 64'(padOutB), 64'h0);
    rdA(5'h0C, 32'h0000_0000, "R1 dirout reset");
    rdA(5'h10, 32'hFFFF_FFFF, "R1 R7 dirin reset");
    rdA(5'h04, 32'h0000_0000, "R1 latch reset");

    // R3 / R4: merges leave zero-written bits alone
    wrA(5'h04, 32'h0000_00F0);
    check("R3 set", 64'(padOutA), 64'h0000_00F0);
    wrA(5'h04, 32'h0F00_0000);
    check("R3 set keeps others", 64'(padOutA), 64'h0F00_00F0);
    wrA(5'h08, 32'h0000_0030);
    check("R4 clear", 64'(padOutA), 64'h0F00_00C0);
    rdA(5'h04, 32'h0F00_00C0, "R8 latch readback");
    rdA(5'h08, 32'h0000_0000, "R8 clear reads zero");

    // R5 / R10
    wrA(5'h00, 32'h1234_5678);
    check("R5 direct load", 64'(padOutA), 64'h1234_5678);
    check("R10 driven while input", 64'(padOeA), 64'h0);

    // R6 / R7 shared direction
    wrA(5'h0C, 32'h0000_FFFF);
    check("R6 oe follows dirout", 64'(padOeA), 64'h0000_FFFF);
    rdA(5'h10, 32'hFFFF_0000, "R7 dirin is complement");
    wrA(5'h10, 32'hFF00_FF00);
    check("R7 dirin write", 64'(padOeA), 64'h00FF_00FF);
    rdA(5'h0C, 32'h00FF_00FF, "R6 R7 dirout after dirin");

    // R9 unmapped and misaligned
    wrA(5'h14, 32'hFFFF_FFFF);
    wrA(5'h1C, 32'hFFFF_FFFF);
    wrA(5'h02, 32'h0000_0000);
    wrA(5'h0E, 32'hFFFF_FFFF);
    check("R9 latch untouched", 64'(padOutA), 64'h1234_5678);
    check("R9 dir untouched", 64'(padOeA), 64'h00FF_00FF);
    rdA(5'h14, 32'h0, "R9 unmapped read");
    rdA(5'h01, 32'h0, "R9 misaligned read");

    // R2 synchronizer latency
    padInA = 32'h0F1E_2D3C;
    rdA(5'h00, 32'h5A5A_A5A5, "R2 first edge old");
    rdA(5'h00, 32'h5A5A_A5A5, "R2 second edge old");
    rdA(5'h00, 32'h0F1E_2D3C, "R2 third edge new");

    // R11 / R12 on mirrored, byte-swapped instance
    wrB(5'h04, 16'h0001);
    check("R11 R12 set maps to line 7", 64'(padOutB), 64'h0080);
    rdB(5'h04, 16'h0001, "R11 R12 latch view");
    wrB(5'h0C, 16'h00C0);
    check("R11 R12 dirout lines 0,1", 64'(padOeB), 64'h0003);
    rdB(5'h10, 16'hFF3F, "R11 R12 dirin view");
    wrB(5'h08, 16'h0001);
    check("R11 R4 clear line 7", 64'(padOutB), 64'h0000);
    padInB = 16'h8001;
    for (int i = 0; i < 3; i++) @(negedge clk);
    rdB(5'h00, 16'h0180, "R11 R12 level view");

    for (int i = 0; i < 3; i++) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule